// File: doc/BRIEF.md
# Serial Flash Clock Generator with Chip-Select Gating

This block derives the serial clock for a flash controller from the core clock. A counter steps from zero up to a programmed last value and then wraps, so the serial period is that value plus one core cycles. The clock sits at its active level while the count is at or below a second programmed compare point, and at the idle level for the rest of the period. A bypass input replaces the divider with the core clock itself, giving divide-by-one operation.

The clock runs only while it is needed. A chip-select-active input from the phase sequencer starts it, and one of four gating modes decides what happens when chip select drops. The clock can stop at once, finish the current period and add one or two whole periods, or run all the time. The idle level is programmable. Along with the clock the block gives the sequencer two one-core-cycle strobes. One marks the leading edge of each serial clock, where output data is driven. The other marks the trailing edge, where input data is sampled.

Programming rule for divider mode: `div_last` = N, with N at least 1, so the period is N+1 core cycles. `high_last` = floor((N+1)/2) - 1, so the clock is active for high_last+1 cycles.

Top module: `sclk_gen`

## Requirements
- R1: In divider mode the serial period is `div_last`+1 core cycles, and `drive_stb` pulses exactly once per period, in the cycle where the period's count is 0.
- R2: In divider mode `sclk` is at its active level for `high_last`+1 consecutive core cycles of each period (counts 0 to `high_last`) and at the idle level for the remaining cycles.
- R3: `sample_stb` pulses exactly once per period, in the first idle-level cycle (count `high_last`+1). In divider mode it is never high in the same cycle as `drive_stb`.
- R4: With `bypass` high, `sclk` follows the core clock while running: active level while `clk` is high, idle level while `clk` is low. Both strobes are high in every running cycle.
- R5: `idle_high`=1 makes the idle level 1 and the active level 0. `idle_high`=0 makes the idle level 0 and the active level 1. When the clock is not running, `sclk` holds the idle level.
- R6: Gating mode 0 (`gate_mode`=0) stops the clock in the cycle after `cs_active` is seen low, even in the middle of a period. From then on `sclk` is idle and both strobes are low.
- R7: Gating modes 1 and 2 finish the period in progress when `cs_active` drops. They then run exactly 1 (mode 1) or 2 (mode 2) more whole periods, each with one `drive_stb`, and stop at the idle level.
- R8: Gating mode 3 keeps the clock running whether `cs_active` is high or low.
- R9: One core cycle after `cs_active` rises, the count restarts at 0. `sclk` is then at the active level and `drive_stb` is high, in every gating mode, including one where the clock was already running.
- R10: While `rst_n` is low and in the cycle after it, `drive_stb` and `sample_stb` are low. After reset the clock is stopped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Synchronous reset, active low |
| div_last | input | 8 | Last count of a period (N). Also the low compare point |
| high_last | input | 8 | Last count of the active phase |
| bypass | input | 1 | 1 selects divide-by-one (core clock passed through) |
| idle_high | input | 1 | Idle level of `sclk` |
| gate_mode | input | 2 | 0 stop at once, 1 or 2 extra periods, 3 free running |
| cs_active | input | 1 | Chip select is active (from the sequencer) |
| sclk | output | 1 | Serial clock |
| drive_stb | output | 1 | One-cycle strobe at each leading edge |
| sample_stb | output | 1 | One-cycle strobe at each trailing edge |

## Verification
A table of eight configurations drives the main function. It covers even and odd periods, the shortest period of two cycles, a long period of ten, both idle levels, bypass with each idle level, and every gating mode. Counting active cycles and both strobes over three whole periods shows whether the period and the high/low split follow the programmed compare points, including the rounding for odd periods. Counting drive strobes over four periods after chip select drops tells the four gating modes apart: 0, 1, 2 or 4 strobes. Directed cases add a drop in the middle of a period under mode 0, the low half of the core clock in bypass, and a reset while the clock is running.

// File: rtl/sclk_pkg.sv
// Package: shared types for the serial clock generator.
// Assumes: gate mode encoding is fixed by software (0..3).
package sclk_pkg;

    typedef enum logic [1:0] {
        GATE_STRICT = 2'd0,   // stop as soon as chip select drops
        GATE_TAIL1  = 2'd1,   // one extra whole period
        GATE_TAIL2  = 2'd2,   // two extra whole periods
        GATE_FREE   = 2'd3    // never stop
    } gate_mode_e;

endpackage

// File: rtl/sclk_gate_ctl.sv
// Module: sclk_gate_ctl
// Decides whether the serial clock runs, using chip select and the gating mode.
// Also flags the start of a transaction (the rising edge of chip select).
// Assumes: period_wrap is high in the last cycle of each serial period.
module sclk_gate_ctl
    import sclk_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] mode,
    input  logic       cs_active,
    input  logic       period_wrap,
    output logic       run_q,
    output logic       start
);

    logic       cs_q;
    logic [1:0] tail_left;
    logic       run_d;
    gate_mode_e mode_e;

    assign mode_e = gate_mode_e'(mode);
    assign start  = cs_active & ~cs_q;

    // Next-cycle run decision from chip select, mode and the tail budget.
    always_comb begin
        if (mode_e == GATE_FREE || cs_active) begin
            run_d = 1'b1;
        end else if (mode_e == GATE_STRICT) begin
            run_d = 1'b0;
        end else begin
            run_d = run_q & ~(period_wrap & (tail_left == 2'd0));
        end
    end

    // Keep the previous chip select level to find transaction starts.
    always_ff @(posedge clk) begin
        if (!rst_n) cs_q <= 1'b0;
        else        cs_q <= cs_active;
    end

    // Tail budget: load from the mode while selected, count down on wraps after.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tail_left <= 2'd0;
        end else if (cs_active) begin
            tail_left <= mode;
        end else if (run_q && period_wrap && tail_left != 2'd0) begin
            tail_left <= tail_left - 2'd1;
        end
    end

    // Registered run flag.
    always_ff @(posedge clk) begin
        if (!rst_n) run_q <= 1'b0;
        else        run_q <= run_d;
    end

endmodule

// File: rtl/sclk_phase_cnt.sv
// Module: sclk_phase_cnt
// Phase counter for the divided clock. It counts 0..div_last and wraps, and
// from the count it decodes the active phase and the leading/trailing marks.
// Assumes: in divider mode div_last >= 1 and high_last < div_last.
module sclk_phase_cnt #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             start,
    input  logic             bypass,
    input  logic [CNT_W-1:0] div_last,
    input  logic [CNT_W-1:0] high_last,
    output logic             period_wrap,
    output logic             phase_act,
    output logic             lead_mark,
    output logic             trail_mark
);

    localparam int EXT_W = CNT_W + 1;

    logic [CNT_W-1:0] cnt_q;
    logic [EXT_W-1:0] trail_pt;

    assign trail_pt    = {1'b0, high_last} + EXT_W'(1);
    assign period_wrap = bypass | (cnt_q >= div_last);
    assign phase_act   = run & (cnt_q <= high_last);
    assign lead_mark   = run & (cnt_q == '0);
    assign trail_mark  = run & ({1'b0, cnt_q} == trail_pt);

    // Count position inside the serial period; restart on a transaction start.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (start || bypass || !run || period_wrap) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + CNT_W'(1);
        end
    end

endmodule

// File: rtl/sclk_out_mux.sv
// Module: sclk_out_mux
// Chooses between the divided clock and the bypassed core clock, applies
// the idle level, and gives the drive and sample strobes.
// Assumes: phase_act and the marks are already qualified by run.
module sclk_out_mux (
    input  logic clk,
    input  logic bypass,
    input  logic idle_high,
    input  logic run,
    input  logic phase_act,
    input  logic lead_mark,
    input  logic trail_mark,
    output logic sclk,
    output logic drive_stb,
    output logic sample_stb
);

    // Output clock level: active is the opposite of the idle level.
    always_comb begin
        if (bypass) sclk = run ? (idle_high ^ clk) : idle_high;
        else        sclk = phase_act ? ~idle_high : idle_high;
    end

    // Strobes: every running cycle in bypass, else the decoded marks.
    always_comb begin
        drive_stb  = bypass ? run : lead_mark;
        sample_stb = bypass ? run : trail_mark;
    end

endmodule

// File: rtl/sclk_gen.sv
// Module: sclk_gen (top)
// Serial flash clock generator with programmable divide, divide-by-one
// bypass, idle level and chip-select-aware gating.
// Assumes: inputs are synchronous to clk; configuration changes only while stopped.
module sclk_gen #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] div_last,
    input  logic [CNT_W-1:0] high_last,
    input  logic             bypass,
    input  logic             idle_high,
    input  logic [1:0]       gate_mode,
    input  logic             cs_active,
    output logic             sclk,
    output logic             drive_stb,
    output logic             sample_stb
);

    logic run_q;
    logic start;
    logic period_wrap;
    logic phase_act;
    logic lead_mark;
    logic trail_mark;

    sclk_gate_ctl u_gate (
        .clk         (clk),
        .rst_n       (rst_n),
        .mode        (gate_mode),
        .cs_active   (cs_active),
        .period_wrap (period_wrap),
        .run_q       (run_q),
        .start       (start)
    );

    sclk_phase_cnt #(.CNT_W(CNT_W)) u_cnt (
        .clk         (clk),
        .rst_n       (rst_n),
        .run         (run_q),
        .start       (start),
        .bypass      (bypass),
        .div_last    (div_last),
        .high_last   (high_last),
        .period_wrap (period_wrap),
        .phase_act   (phase_act),
        .lead_mark   (lead_mark),
        .trail_mark  (trail_mark)
    );

    sclk_out_mux u_mux (
        .clk        (clk),
        .bypass     (bypass),
        .idle_high  (idle_high),
        .run        (run_q),
        .phase_act  (phase_act),
        .lead_mark  (lead_mark),
        .trail_mark (trail_mark),
        .sclk       (sclk),
        .drive_stb  (drive_stb),
        .sample_stb (sample_stb)
    );

endmodule

// File: rtl/sclk_gen_chk.sv
// Module: sclk_gen_chk
// Property checker bound to sclk_gen. It observes ports only.
module sclk_gen_chk #(
    parameter int CNT_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic [CNT_W-1:0] div_last,
    input logic [CNT_W-1:0] high_last,
    input logic             bypass,
    input logic             idle_high,
    input logic [1:0]       gate_mode,
    input logic             cs_active,
    input logic             sclk,
    input logic             drive_stb,
    input logic             sample_stb
);

    // R10: reset leaves both strobes low in the following cycle.
    assert_reset_quiet_R10: assert property (@(posedge clk)
        !rst_n |=> (!drive_stb && !sample_stb));

    // R6: strict gating with chip select low silences the strobes next cycle.
    assert_strict_stop_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs_active && gate_mode == 2'd0) |=> (!drive_stb && !sample_stb));

    // R3: in divider mode leading and trailing marks never coincide.
    assert_strobe_split_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !bypass |-> !(drive_stb && sample_stb));

    // R9: a chip select rise restarts the period with a leading edge.
    assert_start_edge_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cs_active) |=> drive_stb);

    // R1: with a period of two or more, a leading mark is not repeated back to back.
    assert_single_lead_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (drive_stb && !bypass && div_last != '0) |=> (!drive_stb || bypass || $changed(div_last)));

    // R8: free-running bypass strobes in every cycle.
    assert_free_bypass_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (bypass && $past(gate_mode) == 2'd3 && $past(rst_n)) |-> drive_stb);

endmodule

bind sclk_gen sclk_gen_chk #(.CNT_W(CNT_W)) chk_i (.*);

// File: tb/sclk_gen_tb_top.sv
module sclk_gen_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] div_last = 8'd1;
    logic [7:0] high_last = 8'd0;
    logic       bypass = 1'b0;
    logic       idle_high = 1'b0;
    logic [1:0] gate_mode = 2'd0;
    logic       cs_active = 1'b0;
    logic       sclk;
    logic       drive_stb;
    logic       sample_stb;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;   // 250 MHz

    sclk_gen dut_i (
        .clk(clk), .rst_n(rst_n), .div_last(div_last), .high_last(high_last),
        .bypass(bypass), .idle_high(idle_high), .gate_mode(gate_mode),
        .cs_active(cs_active), .sclk(sclk), .drive_stb(drive_stb),
        .sample_stb(sample_stb)
    );

    // Vector fields: [11:4] N, [3] bypass, [2] idle level, [1:0] gating mode
    localparam logic [11:0] VEC [0:7] = '{
        {8'd3, 1'b0, 1'b0, 2'd0},
        {8'd4, 1'b0, 1'b1, 2'd1},
        {8'd1, 1'b0, 1'b0, 2'd2},
        {8'd7, 1'b0, 1'b1, 2'd3},
        {8'd0, 1'b1, 1'b0, 2'd1},
        {8'd2, 1'b0, 1'b0, 2'd2},
        {8'd1, 1'b1, 1'b1, 2'd0},
        {8'd9, 1'b0, 1'b0, 2'd1}
    };

    task automatic chk(input string req, input int act, input int exp, input string what);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic park();
        @(negedge clk);
        gate_mode = 2'd0;
        cs_active = 1'b0;
        bypass    = 1'b0;
        repeat (2) tick();
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("  Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) tick();
        // R10: state while in reset
        chk("R10", sclk, 0, "sclk in reset");
        chk("R10", drive_stb | sample_stb, 0, "strobes in reset");
        @(negedge clk);
        rst_n = 1'b1;
        tick();
        chk("R10", drive_stb | sample_stb, 0, "strobes after reset");

        for (int v = 0; v < 8; v++) begin
            int n, byp, idl, md, hi, per, w;
            int act_cnt, drv_cnt, smp_cnt, tail_cnt;
            n   = int'(VEC[v][11:4]);
            byp = int'(VEC[v][3]);
            idl = int'(VEC[v][2]);
            md  = int'(VEC[v][1:0]);
            hi  = byp ? 0 : ((n + 1) / 2 - 1);
            per = byp ? 1 : n + 1;
            w   = 3 * per;
            park();
            @(negedge clk);
            div_last  = 8'(n);
            high_last = 8'(hi);
            bypass    = byp[0];
            idle_high = idl[0];
            gate_mode = 2'(md);
            repeat (3) tick();
            if (md != 3) chk("R5", sclk, idl, $sformatf("vec%0d idle level before start", v));
            @(negedge clk);
            cs_active = 1'b1;
            act_cnt = 0; drv_cnt = 0; smp_cnt = 0;
            for (int k = 0; k < w; k++) begin
                tick();
                if (k == 0) begin
                    // R9: first cycle after the rise
                    chk("R9", sclk, 1 - idl, $sformatf("vec%0d first level", v));
                    chk("R9", drive_stb, 1, $sformatf("vec%0d first drive strobe", v));
                end
                if (sclk != idl[0]) act_cnt++;
                if (drive_stb) drv_cnt++;
                if (sample_stb) smp_cnt++;
                if (!byp && drive_stb && sample_stb)
                    chk("R3", 1, 0, $sformatf("vec%0d strobes together", v));
            end
            chk(byp ? "R4" : "R2", act_cnt, byp ? w : 3 * (hi + 1), $sformatf("vec%0d active cycles", v));
            chk(byp ? "R4" : "R1", drv_cnt, byp ? w : 3, $sformatf("vec%0d drive strobes", v));
            chk(byp ? "R4" : "R3", smp_cnt, byp ? w : 3, $sformatf("vec%0d sample strobes", v));
            @(negedge clk);
            cs_active = 1'b0;
            tail_cnt = 0;
            for (int k = 0; k < 4 * per; k++) begin
                tick();
                if (drive_stb) tail_cnt++;
            end
            // R6 mode 0 -> 0, R7 modes 1/2 -> 1/2, R8 mode 3 -> 4
            chk(md == 0 ? "R6" : (md == 3 ? "R8" : "R7"), tail_cnt, (md == 3) ? 4 : md,
                $sformatf("vec%0d strobes after deselect", v));
            if (md != 3) chk("R5", sclk, idl, $sformatf("vec%0d idle level after stop", v));
        end

        // R6: strict gating stops in the middle of a period
        park();
        @(negedge clk);
        div_last = 8'd5; high_last = 8'd2; idle_high = 1'b0;
        cs_active = 1'b1;
        repeat (2) tick();
        chk("R6", sclk, 1, "mid-period level before drop");
        @(negedge clk);
        cs_active = 1'b0;
        tick();
        chk("R6", sclk, 0, "level right after drop");
        chk("R6", drive_stb | sample_stb, 0, "strobes right after drop");

        // R4: low half of the core clock in bypass gives the idle level
        park();
        @(negedge clk);
        bypass = 1'b1; idle_high = 1'b1; gate_mode = 2'd3;
        repeat (2) tick();
        chk("R4", sclk, 0, "bypass high half");
        @(negedge clk);
        #1;
        chk("R4", sclk, 1, "bypass low half");

        // R10: reset while running
        @(negedge clk);
        rst_n = 1'b0;
        tick();
        chk("R10", drive_stb | sample_stb, 0, "strobes after reset while running");
        chk("R10", sclk, 1, "idle level after reset while running");
        @(negedge clk);
        rst_n = 1'b1;

        done = 1'b1;
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule